// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block resolves one source operand for a two-operand instruction. It takes a mode code, the values of a base and an index register already read from the register file, a constant field from the instruction and an operand size. From these it either returns a value straight away or forms an effective address and fetches the operand from memory over a request/valid handshake. The memory-indirect mode chains two dependent reads. The auto-increment and auto-decrement modes also produce a base-register writeback value with a one-cycle enable.

The unit is sequenced by a small state machine: idle, address, first read, second read and done. The inputs are captured when a start request is accepted, so the issuing stage may change them on the next cycle. Instruction decode, the register file, the ALU and exception handling sit outside the block.

Top module: `opnd_fetch`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `operand_valid_o`, `err_o` and `wb_en_o` are all low.
- R2: Mode 1 returns `base_val_i` and mode 2 returns `const_i`. Neither mode issues a memory request, and `operand_valid_o` rises in the second cycle after the cycle in which start was sampled.
- R3: Mode 3 reads one word at `base_val_i + const_i`.
- R4: Mode 4 reads at `base_val_i`, mode 5 reads at `base_val_i + index_val_i`, and mode 6 reads at `const_i`. Each mode makes exactly one read.
- R5: Mode 7 reads at `base_val_i`, then reads again at the word that the first read returned. The operand is the data of the second read.
- R6: The step d equals `1 << size_i`, with `size_i` = 0,1,2,3 meaning 1,2,4,8 bytes. Mode 8 reads at `base_val_i` and writes back `base_val_i + d`. Mode 9 reads at `base_val_i` and writes back `base_val_i - d`.
- R7: Mode 10 reads at `const_i + base_val_i + (index_val_i << size_i)`.
- R8: All address and writeback arithmetic is 32-bit and wraps modulo 2^32.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until a cycle with `mem_rvalid_i` high. The data accepted in that cycle is the data used.
- R10: `operand_valid_o` is a one-cycle pulse. `wb_en_o` pulses in that same cycle for modes 8 and 9 only.
- R11: A start request is accepted only when `busy_o` is low. A start that arrives while busy has no effect.
- R12: Mode codes 0 and 11 to 15 return operand 0 with `err_o` high in the valid cycle, and issue no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to resolve an operand |
| mode_i | input | 4 | Addressing mode code, 1 to 10 |
| base_val_i | input | 32 | Base register value |
| index_val_i | input | 32 | Index register value |
| const_i | input | 32 | Immediate, displacement or absolute address |
| size_i | input | 2 | log2 of operand size in bytes |
| busy_o | output | 1 | Unit is working on a request |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 32 | Read data |
| operand_valid_o | output | 1 | Operand ready, one-cycle pulse |
| operand_o | output | 32 | Resolved operand |
| err_o | output | 1 | Illegal mode, qualified by operand_valid_o |
| wb_en_o | output | 1 | Base-register writeback enable |
| wb_val_o | output | 32 | Base-register writeback value |

## Verification
The bench runs the memory-indirect mode against a memory whose words differ from their addresses. A design that returned the pointer, or that reused the first address for the second read, would give a wrong operand or a wrong second request address. Address sums are tested at the top of the 32-bit range, and auto-decrement is tested from zero, so a design that saturates or extends the sum gives wrong addresses and wrong writeback values. Scaled mode is run with every size code, so a wrong shift or a byte multiplier shows up as a wrong address. Two further cases are a slow memory, where the request address must not move, and a second start while busy, which a faulty design would take as a second operand.

// File: rtl/opf_pkg.sv
package opf_pkg;
  // mode encoding is decoded by the issuing stage
  typedef enum logic [3:0] {
    MD_REG  = 4'd1,
    MD_IMM  = 4'd2,
    MD_DISP = 4'd3,
    MD_RIND = 4'd4,
    MD_IDX  = 4'd5,
    MD_ABS  = 4'd6,
    MD_MIND = 4'd7,
    MD_AINC = 4'd8,
    MD_ADEC = 4'd9,
    MD_SCL  = 4'd10
  } opf_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MEM1,
    ST_MEM2,
    ST_DONE
  } opf_state_e;
endpackage

// File: rtl/opf_agen.sv
module opf_agen
  import opf_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  opf_mode_e         mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     index_i,
  input  logic [AW-1:0]     cval_i,
  input  logic [SZW-1:0]    size_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     wb_val_o,
  output logic [AW-1:0]     direct_val_o,
  output logic              mem_o,
  output logic              indirect_o,
  output logic              wb_o,
  output logic              illegal_o
);
  localparam int NSH = 1 << SZW;

  logic [AW-1:0] scaled [NSH];
  logic [AW-1:0] step;

  for (genvar g = 0; g < NSH; g++) begin : g_scale
    assign scaled[g] = index_i << g;
  end

  assign step = {{(AW-1){1'b0}}, 1'b1} << size_i;

  always_comb begin
    ea_o         = base_i;
    wb_val_o     = base_i;
    direct_val_o = '0;
    mem_o        = 1'b1;
    indirect_o   = 1'b0;
    wb_o         = 1'b0;
    illegal_o    = 1'b0;
    case (mode_i)
      MD_REG:  begin mem_o = 1'b0; direct_val_o = base_i; end
      MD_IMM:  begin mem_o = 1'b0; direct_val_o = cval_i; end
      MD_DISP: ea_o = base_i + cval_i;
      MD_RIND: ea_o = base_i;
      MD_IDX:  ea_o = base_i + index_i;
      MD_ABS:  ea_o = cval_i;
      MD_MIND: indirect_o = 1'b1;
      MD_AINC: begin wb_o = 1'b1; wb_val_o = base_i + step; end
      MD_ADEC: begin wb_o = 1'b1; wb_val_o = base_i - step; end
      MD_SCL:  ea_o = cval_i + base_i + scaled[size_i];
      default: begin mem_o = 1'b0; illegal_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       mem_i,
  input  logic       indirect_i,
  input  logic       rvalid_i,
  output opf_state_e state_o,
  output logic       accept_o,
  output logic       ptr_done_o,
  output logic       rd_done_o
);
  opf_state_e state_q, state_d;

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign ptr_done_o = (state_q == ST_MEM1) && rvalid_i && indirect_i;
  assign rd_done_o  = rvalid_i && (((state_q == ST_MEM1) && !indirect_i) ||
                                   (state_q == ST_MEM2));
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: state_d = mem_i ? ST_MEM1 : ST_DONE;
      ST_MEM1: if (rvalid_i) state_d = indirect_i ? ST_MEM2 : ST_DONE;
      ST_MEM2: if (rvalid_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
  import opf_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [AW-1:0]  base_val_i,
  input  logic [AW-1:0]  index_val_i,
  input  logic [AW-1:0]  const_i,
  input  logic [SZW-1:0] size_i,
  output logic           busy_o,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_rvalid_i,
  input  logic [AW-1:0]  mem_rdata_i,
  output logic           operand_valid_o,
  output logic [AW-1:0]  operand_o,
  output logic           err_o,
  output logic           wb_en_o,
  output logic [AW-1:0]  wb_val_o
);
  opf_state_e     state;
  logic           accept, ptr_done, rd_done;
  opf_mode_e      mode_q;
  logic [AW-1:0]  base_q, index_q, cval_q;
  logic [SZW-1:0] size_q;
  logic [AW-1:0]  ea, wb_val, direct_val;
  logic           need_mem, indirect, wb_mode, illegal;
  logic [AW-1:0]  addr_q, operand_q, wb_val_q;
  logic           err_q, wb_q;

  opf_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_i      (need_mem),
    .indirect_i (indirect),
    .rvalid_i   (mem_rvalid_i),
    .state_o    (state),
    .accept_o   (accept),
    .ptr_done_o (ptr_done),
    .rd_done_o  (rd_done)
  );

  opf_agen #(.AW(AW), .SZW(SZW)) u_agen (
    .mode_i       (mode_q),
    .base_i       (base_q),
    .index_i      (index_q),
    .cval_i       (cval_q),
    .size_i       (size_q),
    .ea_o         (ea),
    .wb_val_o     (wb_val),
    .direct_val_o (direct_val),
    .mem_o        (need_mem),
    .indirect_o   (indirect),
    .wb_o         (wb_mode),
    .illegal_o    (illegal)
  );

  // request fields are captured so the issuer may move on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_REG;
      base_q  <= '0;
      index_q <= '0;
      cval_q  <= '0;
      size_q  <= '0;
    end else if (accept) begin
      mode_q  <= opf_mode_e'(mode_i);
      base_q  <= base_val_i;
      index_q <= index_val_i;
      cval_q  <= const_i;
      size_q  <= size_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      operand_q <= '0;
      wb_val_q  <= '0;
      err_q     <= 1'b0;
      wb_q      <= 1'b0;
    end else begin
      if (state == ST_ADDR) begin
        addr_q    <= ea;
        operand_q <= direct_val;
        wb_val_q  <= wb_val;
        err_q     <= illegal;
        wb_q      <= wb_mode;
      end
      if (ptr_done) addr_q    <= mem_rdata_i;
      if (rd_done)  operand_q <= mem_rdata_i;
    end
  end

  assign busy_o          = (state != ST_IDLE);
  assign mem_req_o       = (state == ST_MEM1) || (state == ST_MEM2);
  assign mem_addr_o      = addr_q;
  assign operand_valid_o = (state == ST_DONE);
  assign operand_o       = operand_q;
  assign err_o           = operand_valid_o && err_q;
  assign wb_en_o         = operand_valid_o && wb_q;
  assign wb_val_o        = wb_val_q;
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          operand_valid_o,
  input logic [AW-1:0] operand_o,
  input logic          err_o,
  input logic          wb_en_o
);
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    operand_valid_o |=> !operand_valid_o);

  p_wb_with_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> operand_valid_o);

  p_err_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> operand_valid_o && (operand_o == '0) && !wb_en_o);

  p_idle_no_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !operand_valid_o);

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
endmodule

bind opnd_fetch opf_checker #(.AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .busy_o          (busy_o),
  .mem_req_o       (mem_req_o),
  .mem_addr_o      (mem_addr_o),
  .mem_rvalid_i    (mem_rvalid_i),
  .operand_valid_o (operand_valid_o),
  .operand_o       (operand_o),
  .err_o           (err_o),
  .wb_en_o         (wb_en_o)
);

// File: tb/opnd_fetch_test.sv
module opnd_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] base = '0, idx = '0, cval = '0;
  logic [1:0]  size = '0;
  logic        busy, mem_req, op_valid, err, wb_en;
  logic [31:0] mem_addr, operand, wb_val;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 1, cnt = 0;

  // observations of the last operation
  int          nreq, got_lat;
  logic [31:0] req_addr [2];
  logic        moved, waiting;
  logic [31:0] wait_addr;
  logic [31:0] got_op, got_wbv;
  logic        got_err, got_wb, after_quiet, timed_out;

  always #4 clk = ~clk;

  opnd_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .base_val_i(base), .index_val_i(idx), .const_i(cval), .size_i(size),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .operand_valid_o(op_valid), .operand_o(operand), .err_o(err),
    .wb_en_o(wb_en), .wb_val_o(wb_val)
  );

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
  endfunction

  // memory model: data valid after lat cycles of request
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (mem_req) begin
      if (cnt + 1 >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_fn(mem_addr);
        cnt        <= 0;
      end else cnt <= cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (mem_req) begin
      if (waiting && mem_addr != wait_addr) moved = 1'b1;
      waiting   = !mem_rvalid;
      wait_addr = mem_addr;
      if (mem_rvalid) begin
        if (nreq < 2) req_addr[nreq] = mem_addr;
        nreq++;
      end
    end else waiting = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [31:0] b, x, c,
                        input logic [1:0] s);
    nreq = 0; moved = 1'b0; waiting = 1'b0; got_lat = 0; timed_out = 1'b0;
    @(negedge clk);
    mode = m; base = b; idx = x; cval = c; size = s; start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0; mode = '0; base = '0; idx = '0; cval = '0;
      got_lat++;
      if (op_valid) break;
      if (got_lat > 100) begin timed_out = 1'b1; break; end
    end
    got_op = operand; got_err = err; got_wb = wb_en; got_wbv = wb_val;
    @(negedge clk);
    after_quiet = !op_valid && !wb_en && !busy;
    chk("watchdog", 32'(timed_out), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 valid/err/wb", {29'd0, op_valid, err, wb_en}, 0);
  endtask

  task automatic t_direct;
    run_op(4'd1, 32'hCAFE_0001, 32'h5, 32'h77, 2'd2);
    chk("R2 reg value", got_op, 32'hCAFE_0001);
    chk("R2 reg latency", got_lat, 2);
    chk("R2 reg no req", nreq, 0);
    run_op(4'd2, 32'h1, 32'h2, 32'h8000_0042, 2'd0);
    chk("R2 imm value", got_op, 32'h8000_0042);
    chk("R2 imm no req", nreq, 0);
    chk("R10 no wb reg/imm", 32'(got_wb), 0);
  endtask

  task automatic t_disp;
    run_op(4'd3, 32'h0000_1000, 32'h9, 32'h0000_0100, 2'd2);
    chk("R3 addr", req_addr[0], 32'h0000_1100);
    chk("R3 data", got_op, mem_fn(32'h0000_1100));
    chk("R3 one read", nreq, 1);
  endtask

  task automatic t_simple_mem;
    run_op(4'd4, 32'h0000_2468, 32'h10, 32'h99, 2'd0);
    chk("R4 rind addr", req_addr[0], 32'h0000_2468);
    chk("R4 rind data", got_op, mem_fn(32'h0000_2468));
    run_op(4'd5, 32'h0000_3000, 32'h0000_0024, 32'h99, 2'd0);
    chk("R4 idx addr", req_addr[0], 32'h0000_3024);
    chk("R4 idx one read", nreq, 1);
    run_op(4'd6, 32'h1111_1111, 32'h2222, 32'hABCD_0010, 2'd1);
    chk("R4 abs addr", req_addr[0], 32'hABCD_0010);
    chk("R4 abs data", got_op, mem_fn(32'hABCD_0010));
  endtask

  task automatic t_mind;
    logic [31:0] ptr;
    ptr = mem_fn(32'h0000_4000);
    run_op(4'd7, 32'h0000_4000, 32'h0, 32'h0, 2'd2);
    chk("R5 two reads", nreq, 2);
    chk("R5 first addr", req_addr[0], 32'h0000_4000);
    chk("R5 second addr", req_addr[1], ptr);
    chk("R5 data", got_op, mem_fn(ptr));
  endtask

  task automatic t_auto;
    run_op(4'd8, 32'h0000_5000, 32'h0, 32'h0, 2'd2);
    chk("R6 ainc addr", req_addr[0], 32'h0000_5000);
    chk("R6 ainc wb", got_wbv, 32'h0000_5004);
    chk("R10 ainc wb_en", 32'(got_wb), 1);
    chk("R10 pulse", 32'(after_quiet), 1);
    run_op(4'd9, 32'h0000_5000, 32'h0, 32'h0, 2'd3);
    chk("R6 adec addr", req_addr[0], 32'h0000_5000);
    chk("R6 adec wb", got_wbv, 32'h0000_4FF8);
    chk("R10 adec wb_en", 32'(got_wb), 1);
    run_op(4'd8, 32'h0000_0010, 32'h0, 32'h0, 2'd0);
    chk("R6 ainc byte", got_wbv, 32'h0000_0011);
  endtask

  task automatic t_scaled;
    for (int s = 0; s < 4; s++) begin
      run_op(4'd10, 32'h0001_0000, 32'h0000_0013, 32'h0000_0200, 2'(s));
      chk("R7 scaled addr", req_addr[0], 32'h0001_0200 + (32'h13 << s));
      chk("R10 no wb scaled", 32'(got_wb), 0);
    end
  endtask

  task automatic t_wrap;
    run_op(4'd3, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 2'd0);
    chk("R8 disp wrap", req_addr[0], 32'h0000_0010);
    run_op(4'd9, 32'h0000_0000, 32'h0, 32'h0, 2'd3);
    chk("R8 adec wrap", got_wbv, 32'hFFFF_FFF8);
    run_op(4'd10, 32'hFFFF_FF00, 32'h8000_0001, 32'h0000_0100, 2'd1);
    chk("R8 scaled wrap", req_addr[0], 32'h0000_0002);
  endtask

  task automatic t_slow;
    lat = 5;
    run_op(4'd7, 32'h0000_6000, 32'h0, 32'h0, 2'd2);
    chk("R9 addr stable", 32'(moved), 0);
    chk("R9 slow data", got_op, mem_fn(mem_fn(32'h0000_6000)));
    lat = 1;
  endtask

  task automatic t_busy;
    int vcount;
    logic [31:0] v;
    lat = 4; vcount = 0; v = '0;
    @(negedge clk);
    mode = 4'd6; cval = 32'h0000_7000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    mode = 4'd2; cval = 32'h1234_5678; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (op_valid) begin vcount++; v = operand; end
    end
    chk("R11 one result", vcount, 1);
    chk("R11 first op kept", v, mem_fn(32'h0000_7000));
    lat = 1;
  endtask

  task automatic t_illegal;
    run_op(4'd0, 32'h1, 32'h2, 32'h3, 2'd0);
    chk("R12 mode0 err", 32'(got_err), 1);
    chk("R12 mode0 zero", got_op, 0);
    run_op(4'd13, 32'hFFFF_FFFF, 32'h2, 32'h3, 2'd0);
    chk("R12 mode13 err", 32'(got_err), 1);
    chk("R12 mode13 zero", got_op, 0);
    chk("R12 no req", nreq, 0);
    run_op(4'd4, 32'h0000_0100, 32'h0, 32'h0, 2'd0);
    chk("R12 legal no err", 32'(got_err), 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_disp();
    t_simple_mem();
    t_mind();
    t_auto();
    t_scaled();
    t_wrap();
    t_slow();
    t_busy();
    t_illegal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule